// File: doc/BRIEF.md
# Mask-Selected Multi-Way Vector ALU

This block runs one arithmetic instruction across a vector of integer elements, and each element picks its own operation. The instruction carries a menu of up to eight 3-bit operation codes. One, two or three mask words give every element a selector of 1, 2 or 3 bits, and that selector chooses the menu entry the element uses. The result is a two-, four- or eight-way choice of operation per element inside a single instruction. The operations are no operation, add, load, subtract, multiply and divide, plus reversed forms of subtract and divide.

A start strobe captures the destination vector, the source vector, the masks, the way count, the menu and an optional element window. One shared datapath then works through the elements one per cycle, from the low index of the window up to the high index. Elements outside the window keep their destination value. The block holds busy while it works and pulses done when the result vector is complete. A sticky flag reports an integer division by zero.

Top module: `mwv_vector_alu`

## Requirements
- R1: The selector for element i is {mask2[i], mask1[i], mask0[i]}, with mask0 as the least significant bit. A mask beyond the way count reads as 0: way count 0 or 1 uses mask0 only, 2 uses mask0 and mask1, and 3 uses all three. Menu entry k is op_fields_i[3k+2:3k], and the selector picks the entry.
- R2: Code 000 leaves the element unchanged. Code 010 writes dst+src. Code 100 writes src.
- R3: Code 101 writes dst-src and code 001 writes src-dst, both in two's complement modulo 2^DATA_W.
- R4: Code 110 writes the low DATA_W bits of dst*src.
- R5: Code 111 writes the unsigned quotient dst/src and code 011 writes the unsigned quotient src/dst.
- R6: A division whose divisor is zero writes all ones to the element and sets div0_o. div0_o stays set until the next accepted start clears it.
- R7: With range_en_i high, only the elements from range_lo_i to range_hi_i change. With range_en_i low, all elements from 0 to N_ELEM-1 are processed and the range inputs are ignored.
- R8: If the effective low index is above the high index, no element changes, busy_o never rises and done_o pulses in the cycle after start.
- R9: After an accepted start, busy_o is high for exactly hi-lo+1 cycles. done_o is a one-cycle pulse in the cycle after the last element. result_o holds the final vector from done until the next accepted start.
- R10: A start while busy_o is high is ignored: the running job and its inputs are unaffected and no extra done pulse is produced.
- R11: After reset, result_o is zero and busy_o, done_o and div0_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| way_cnt_i | input | 2 | Number of masks in use (0 is treated as 1) |
| mask0_i | input | N_ELEM | Selector bit 0 for each element |
| mask1_i | input | N_ELEM | Selector bit 1 for each element |
| mask2_i | input | N_ELEM | Selector bit 2 for each element |
| op_fields_i | input | 24 | Eight 3-bit operation codes; entry k is at bits 3k+2:3k |
| range_en_i | input | 1 | Restrict processing to an element window |
| range_lo_i | input | IDX_W | First element of the window |
| range_hi_i | input | IDX_W | Last element of the window |
| dst_i | input | N_ELEM*DATA_W | Destination vector, element i at bits i*DATA_W |
| src_i | input | N_ELEM*DATA_W | Source vector, same layout |
| result_o | output | N_ELEM*DATA_W | Result vector, same layout |
| busy_o | output | 1 | An element is being processed this cycle |
| done_o | output | 1 | One-cycle pulse when the result is complete |
| div0_o | output | 1 | Sticky divide-by-zero flag for the current job |

## Verification
The hardest case to reach from the ports is one element whose mask bits select exactly the division entry while its divisor is zero, followed by the flag clearing on the next job. The bench forces all three mask bits of element 0 high over a zero source element. It then runs a job whose menu has no reachable division. A second hard case is a start strobe that arrives during a run. The bench raises it mid-job with different vectors and checks both the unchanged result and the absence of a second done pulse. The empty window (low above high) and single-element windows at the top index also need deliberate stimulus.

// File: rtl/mwv_pkg.sv
package mwv_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 3'b000,
        OP_RSUB = 3'b001,
        OP_ADD  = 3'b010,
        OP_RDIV = 3'b011,
        OP_LOAD = 3'b100,
        OP_SUB  = 3'b101,
        OP_MUL  = 3'b110,
        OP_DIV  = 3'b111
    } op_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/mwv_op_select.sv
module mwv_op_select
    import mwv_pkg::*;
#(
    parameter int SEL_W = 3,
    localparam int MENU = 1 << SEL_W,
    localparam int OPF_W = MENU * OP_W
) (
    input  logic [1:0]       way_cnt,
    input  logic [SEL_W-1:0] mask_bits,
    input  logic [OPF_W-1:0] op_fields,
    output op_e              op
);

    logic [OP_W-1:0]  menu [MENU];
    logic [SEL_W-1:0] sel;
    logic [1:0]       n_masks;

    // A way count of zero behaves like a single mask.
    assign n_masks = (way_cnt == 2'd0) ? 2'd1 : way_cnt;

    for (genvar g = 0; g < MENU; g++) begin : g_menu
        assign menu[g] = op_fields[g*OP_W +: OP_W];
    end

    for (genvar b = 0; b < SEL_W; b++) begin : g_sel
        assign sel[b] = mask_bits[b] && (b < int'(n_masks));
    end

    assign op = op_e'(menu[sel]);

endmodule

// File: rtl/mwv_elem_alu.sv
module mwv_elem_alu
    import mwv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] d,
    input  logic [DATA_W-1:0] s,
    output logic [DATA_W-1:0] y,
    output logic              div_zero
);

    logic [DATA_W-1:0] num;
    logic [DATA_W-1:0] den;
    logic [DATA_W-1:0] quot;
    logic              den_zero;

    // Reversed division swaps the dividend and the divisor.
    always_comb begin
        if (op == OP_RDIV) begin
            num = s;
            den = d;
        end else begin
            num = d;
            den = s;
        end
        den_zero = (den == '0);
        quot     = den_zero ? '1 : (num / den);
    end

    always_comb begin
        div_zero = 1'b0;
        unique case (op)
            OP_NOP:  y = d;
            OP_RSUB: y = s - d;
            OP_ADD:  y = d + s;
            OP_LOAD: y = s;
            OP_SUB:  y = d - s;
            OP_MUL:  y = d * s;
            OP_RDIV, OP_DIV: begin
                y        = quot;
                div_zero = den_zero;
            end
            default: y = d;
        endcase
    end

endmodule

// File: rtl/mwv_vector_alu.sv
module mwv_vector_alu
    import mwv_pkg::*;
#(
    parameter int N_ELEM = 64,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(N_ELEM),
    localparam int N_MASK = 3,
    localparam int OPF_W = (1 << N_MASK) * OP_W,
    localparam int VEC_W = N_ELEM * DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       way_cnt_i,
    input  logic [N_ELEM-1:0] mask0_i,
    input  logic [N_ELEM-1:0] mask1_i,
    input  logic [N_ELEM-1:0] mask2_i,
    input  logic [OPF_W-1:0] op_fields_i,
    input  logic             range_en_i,
    input  logic [IDX_W-1:0] range_lo_i,
    input  logic [IDX_W-1:0] range_hi_i,
    input  logic [VEC_W-1:0] dst_i,
    input  logic [VEC_W-1:0] src_i,
    output logic [VEC_W-1:0] result_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             div0_o
);

    typedef struct packed {
        phase_e                           phase;
        logic [IDX_W-1:0]                 idx;
        logic [IDX_W-1:0]                 hi;
        logic [1:0]                       ways;
        logic [N_ELEM-1:0]                m0;
        logic [N_ELEM-1:0]                m1;
        logic [N_ELEM-1:0]                m2;
        logic [OPF_W-1:0]                 ops;
        logic [N_ELEM-1:0][DATA_W-1:0]    acc;
        logic [N_ELEM-1:0][DATA_W-1:0]    src;
        logic                             done;
        logic                             div0;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [IDX_W-1:0]  eff_lo_d;
    logic [IDX_W-1:0]  eff_hi_d;
    logic [N_MASK-1:0] elem_mask_d;
    op_e               elem_op_d;
    logic [DATA_W-1:0] elem_res_d;
    logic              elem_dz_d;

    // Window selection: the full vector unless a window is requested.
    assign eff_lo_d = range_en_i ? range_lo_i : '0;
    assign eff_hi_d = range_en_i ? range_hi_i : IDX_W'(N_ELEM - 1);

    assign elem_mask_d = {st_q.m2[st_q.idx], st_q.m1[st_q.idx], st_q.m0[st_q.idx]};

    mwv_op_select #(
        .SEL_W (N_MASK)
    ) u_op_select (
        .way_cnt   (st_q.ways),
        .mask_bits (elem_mask_d),
        .op_fields (st_q.ops),
        .op        (elem_op_d)
    );

    mwv_elem_alu #(
        .DATA_W (DATA_W)
    ) u_elem_alu (
        .op       (elem_op_d),
        .d        (st_q.acc[st_q.idx]),
        .s        (st_q.src[st_q.idx]),
        .y        (elem_res_d),
        .div_zero (elem_dz_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ways = way_cnt_i;
                    st_d.m0   = mask0_i;
                    st_d.m1   = mask1_i;
                    st_d.m2   = mask2_i;
                    st_d.ops  = op_fields_i;
                    st_d.acc  = dst_i;
                    st_d.src  = src_i;
                    st_d.div0 = 1'b0;
                    st_d.idx  = eff_lo_d;
                    st_d.hi   = eff_hi_d;
                    if (eff_lo_d > eff_hi_d) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.phase = PH_RUN;
                    end
                end
            end
            PH_RUN: begin
                st_d.acc[st_q.idx] = elem_res_d;
                if (elem_dz_d) begin
                    st_d.div0 = 1'b1;
                end
                if (st_q.idx == st_q.hi) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.acc;
    assign busy_o   = (st_q.phase == PH_RUN);
    assign done_o   = st_q.done;
    assign div0_o   = st_q.div0;

endmodule

// File: rtl/mwv_checker.sv
module mwv_checker #(
    parameter int RES_W = 2048
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             div0,
    input logic [RES_W-1:0] result
);

    // R9: done is a single-cycle pulse unless a fresh start follows it.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R9: the end of a run is always marked by done.
    assert_fell_busy_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: done never overlaps busy.
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: the result holds while idle with no start.
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    // R10: a run only begins on a start.
    assert_run_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6: the flag is sticky for the rest of a run.
    assert_div0_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && div0) |=> div0);

    // R6: the flag changes only through a start or a running job.
    assert_div0_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(div0));

endmodule

bind mwv_vector_alu mwv_checker #(
    .RES_W (N_ELEM * DATA_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .busy   (busy_o),
    .done   (done_o),
    .div0   (div0_o),
    .result (result_o)
);

// File: tb/mwv_vector_alu_tb_top.sv
module mwv_vector_alu_tb_top;

    localparam int N  = 64;
    localparam int W  = 32;
    localparam int IW = 6;
    localparam int VW = N * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic [1:0]    way_cnt_i;
    logic [N-1:0]  mask0_i, mask1_i, mask2_i;
    logic [23:0]   op_fields_i;
    logic          range_en_i;
    logic [IW-1:0] range_lo_i, range_hi_i;
    logic [VW-1:0] dst_i, src_i, result_o;
    logic          busy_o, done_o, div0_o;

    always #4 clk = ~clk;

    mwv_vector_alu #(.N_ELEM(N), .DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .way_cnt_i(way_cnt_i),
        .mask0_i(mask0_i), .mask1_i(mask1_i), .mask2_i(mask2_i),
        .op_fields_i(op_fields_i), .range_en_i(range_en_i),
        .range_lo_i(range_lo_i), .range_hi_i(range_hi_i),
        .dst_i(dst_i), .src_i(src_i), .result_o(result_o),
        .busy_o(busy_o), .done_o(done_o), .div0_o(div0_o)
    );

    logic [N-1:0][W-1:0] t_dst, t_src;
    logic [VW-1:0] q_vec[$];
    logic          q_dz[$];
    int            q_cyc[$];
    string         q_tag[$];
    int n_cmp = 0;
    int n_bad = 0;
    int busy_cnt = 0;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [W-1:0] model_op(logic [2:0] op, logic [W-1:0] d,
                                              logic [W-1:0] s, output logic dz);
        dz = 1'b0;
        case (op)
            3'b001: return s - d;
            3'b010: return d + s;
            3'b100: return s;
            3'b101: return d - s;
            3'b110: return d * s;
            3'b011: begin dz = (d == 0); return (d == 0) ? '1 : s / d; end
            3'b111: begin dz = (s == 0); return (s == 0) ? '1 : d / s; end
            default: return d;
        endcase
    endfunction

    // Scoreboard monitor: pops one expected item per done pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) busy_cnt++;
            if (done_o) begin
                if (q_vec.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    logic [VW-1:0] ev;
                    string tg;
                    int bad_i;
                    ev = q_vec.pop_front();
                    tg = q_tag.pop_front();
                    bad_i = 0;
                    for (int i = 0; i < N; i++) begin
                        if (result_o[i*W +: W] !== ev[i*W +: W]) begin
                            bad_i = i;
                            break;
                        end
                    end
                    check(result_o === ev, {tg, " result elem"},
                          {32'(bad_i), result_o[bad_i*W +: W]}, {32'(bad_i), ev[bad_i*W +: W]});
                    check(div0_o === q_dz[0], {tg, " R6 div0 flag"}, 64'(div0_o), 64'(q_dz[0]));
                    check(busy_cnt == q_cyc[0], {tg, " R9 busy cycles"}, 64'(busy_cnt), 64'(q_cyc[0]));
                    void'(q_dz.pop_front());
                    void'(q_cyc.pop_front());
                end
                busy_cnt = 0;
            end
        end
    end

    task automatic fill(bit small_src);
        for (int i = 0; i < N; i++) begin
            t_dst[i] = $urandom;
            t_src[i] = small_src && (i % 3 == 0) ? W'($urandom_range(0, 5)) : $urandom;
        end
        mask0_i = {$urandom, $urandom};
        mask1_i = {$urandom, $urandom};
        mask2_i = {$urandom, $urandom};
    endtask

    // Driver: computes the expected vector, pushes it, then pulses start.
    task automatic run_job(string tag, logic [1:0] wc, logic [23:0] opf, logic en,
                           logic [IW-1:0] lo, logic [IW-1:0] hi, bit restart_mid);
        logic [N-1:0][W-1:0] ev;
        logic dz, d1;
        int el, eh, nm, cnt;
        logic [2:0] sel;
        ev = t_dst; dz = 1'b0; cnt = 0;
        el = en ? int'(lo) : 0;
        eh = en ? int'(hi) : N - 1;
        nm = (wc == 2'd0) ? 1 : int'(wc);
        for (int i = el; i <= eh; i++) begin
            sel = {(nm >= 3) ? mask2_i[i] : 1'b0, (nm >= 2) ? mask1_i[i] : 1'b0, mask0_i[i]};
            ev[i] = model_op(opf[3*sel +: 3], ev[i], t_src[i], d1);
            dz = dz | d1;
            cnt++;
        end
        q_vec.push_back(ev); q_dz.push_back(dz); q_cyc.push_back(cnt); q_tag.push_back(tag);
        way_cnt_i = wc; op_fields_i = opf; range_en_i = en;
        range_lo_i = lo; range_hi_i = hi;
        dst_i = t_dst; src_i = t_src;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (restart_mid) begin
            repeat (4) @(negedge clk);
            dst_i = ~t_dst; src_i = {N{32'h1}};
            way_cnt_i = 2'd3; op_fields_i = {8{3'b101}}; range_en_i = 1'b0;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; way_cnt_i = '0; op_fields_i = '0;
        mask0_i = '0; mask1_i = '0; mask2_i = '0;
        range_en_i = 1'b0; range_lo_i = '0; range_hi_i = '0;
        dst_i = '0; src_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(result_o == '0, "R11 result", 64'(result_o[63:0]), 0);
        check(!busy_o, "R11 busy", 64'(busy_o), 0);
        check(!done_o, "R11 done", 64'(done_o), 0);
        check(!div0_o, "R11 div0", 64'(div0_o), 0);

        // R1 R2 R3 R4 R5: eight-way, entry k holds code k; element 0 divides by zero
        fill(1'b1);
        mask0_i[0] = 1'b1; mask1_i[0] = 1'b1; mask2_i[0] = 1'b1; t_src[0] = '0;
        run_job("R1 R2 R3 R4 R5 eight-way", 2'd3,
                {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}, 1'b0, '0, '0, 1'b0);

        // R1 R6: one mask, mask1/mask2 must be ignored (entries 2..7 are divides)
        fill(1'b1);
        run_job("R1 R6 two-way ignores upper masks", 2'd1,
                {3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b100, 3'b101},
                1'b0, '0, '0, 1'b0);

        // R1: way count 0 behaves like one mask
        fill(1'b0);
        run_job("R1 way count zero", 2'd0,
                {3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b001, 3'b010},
                1'b0, '0, '0, 1'b0);

        // R1 R5: four-way with add, reversed divide, multiply, no-op
        fill(1'b1);
        run_job("R1 R5 four-way", 2'd2,
                {3'b111, 3'b111, 3'b111, 3'b111, 3'b000, 3'b110, 3'b011, 3'b010},
                1'b0, '0, '0, 1'b0);

        // R7: window 10..20
        fill(1'b1);
        run_job("R7 window", 2'd3,
                {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}, 1'b1, 6'd10, 6'd20, 1'b0);

        // R7 R9: single element at the top index
        fill(1'b0);
        run_job("R7 R9 single top element", 2'd3,
                {8{3'b010}}, 1'b1, 6'd63, 6'd63, 1'b0);

        // R8: empty window
        fill(1'b0);
        run_job("R8 empty window", 2'd3, {8{3'b100}}, 1'b1, 6'd40, 6'd5, 1'b0);

        // R7: window disabled, reversed range inputs ignored
        fill(1'b0);
        run_job("R7 range ignored", 2'd2,
                {3'b000, 3'b000, 3'b000, 3'b000, 3'b101, 3'b001, 3'b110, 3'b010},
                1'b0, 6'd40, 6'd5, 1'b0);

        // R6: reversed divide by zero destination everywhere
        fill(1'b0);
        for (int i = 0; i < N; i++) t_dst[i] = '0;
        run_job("R6 divide by zero", 2'd3, {8{3'b011}}, 1'b0, '0, '0, 1'b0);

        // R10: start raised mid-run with different operands
        fill(1'b0);
        run_job("R10 start while busy", 2'd3,
                {3'd7, 3'd6, 3'd5, 3'd4, 3'd2, 3'd2, 3'd1, 3'd0}, 1'b0, '0, '0, 1'b1);

        repeat (5) @(negedge clk);
        // R10: no pending expectations left and no stray activity
        check(q_vec.size() == 0, "R10 queue drained", 64'(q_vec.size()), 0);
        check(!busy_o, "R10 idle after jobs", 64'(busy_o), 0);
        summary();
        $finish;
    end

endmodule